// File: doc/BRIEF.md
# Source-selector serial control slave

This block is the two-wire serial slave of an audio/video source-selector chip. It samples the clock and data lines with the system clock and finds START, repeated START and STOP conditions. It checks a 7-bit device address whose lowest bit comes from a strap pin. A write transfer loads a single 8-bit control register. That register drives the output gain, the video mode, the video source and the audio source fields. A read transfer returns a status byte. This byte carries a sticky power-on flag and the digitised results of two three-level switch-detect inputs.

The data line is open drain. The block only says when to pull it low. The analog threshold detectors and the analog power-on reset are outside the block. The detectors arrive as four digital flags. The power-on reset arrives as `rst_ni`.

Top module: `sw_i2c_slave`

## Requirements
- R1: The device address is the 7-bit value 1001000 with its lowest bit replaced by `addr_sel_i`, so the write bytes are 0x90/0x92 and the read bytes are 0x91/0x93. The slave pulls the acknowledge bit low only when the address matches. On a mismatch it leaves SDA released for the rest of the transfer and waits for the next START.
- R2: Bytes arrive MSB first, and bit 0 of the address byte is the direction (0 write, 1 read). The first data byte of a write is loaded into the control register. Its fields map as bit 7 to `gain_o`, bit 6 to `vmode_o`, bits 5..3 to `vsrc_o` and bits 2..0 to `asrc_o`.
- R3: Written bytes after the first data byte are acknowledged and discarded. The control register keeps the first data byte.
- R4: After reset every control output is 0 and `sda_pull_o` is 0.
- R5: The status byte is sent MSB first with these bits:
  - bit 7: power-on flag
  - bit 5: `s1_open_i`
  - bit 4: `s1_gnd_i`
  - bit 3: `s2_open_i`
  - bit 2: `s2_gnd_i`
  - bits 6, 1 and 0: read as 0
- R6: The power-on flag reads 1 in the first status byte sent after reset. Once a read has begun, the flag reads 0 until the next reset.
- R7: A START or STOP at any point aborts the current transfer and resets the bit count. A write cut short before its data-byte acknowledge leaves the control register unchanged.
- R8: A repeated START, with no STOP before it, begins a new address phase. The direction may change across the repeated START.
- R9: During a read, a master acknowledge makes the slave send the status byte again. A master not-acknowledge makes the slave leave SDA released until the next START.
- R10: The slave starts pulling SDA low only while SCL is low. Its drive stays constant while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| addr_sel_i | input | 1 | Strap for the lowest address bit |
| s1_open_i | input | 1 | Detect input 1 is at the high level |
| s1_gnd_i | input | 1 | Detect input 1 is at the low level |
| s2_open_i | input | 1 | Detect input 2 is at the high level |
| s2_gnd_i | input | 1 | Detect input 2 is at the low level |
| gain_o | output | 1 | Audio gain select |
| vmode_o | output | 1 | Video mode select |
| vsrc_o | output | 3 | Video source select |
| asrc_o | output | 3 | Audio source select |

## Verification
A table of writes combines both strap values with matching and non-matching address bytes and with data bytes of different bit patterns. These cases show that the address comparison uses the strap and that every control field lands on the right output. Reads use two different detect patterns and a read of two bytes. These separate the status bit positions and show that the power-on flag clears after the first read. Directed transfers tell apart:
- extra written bytes, which must be dropped;
- a write truncated by STOP, which must leave the register unchanged;
- a byte aborted by a repeated START, after which a new address phase begins;
- a repeated START from a write into a read;
- an address mismatch followed by data, which must be ignored.

// File: rtl/sw_i2c_pkg.sv
package sw_i2c_pkg;
  typedef struct packed {
    logic       gain;
    logic       vmode;
    logic [2:0] vsrc;
    logic [2:0] asrc;
  } ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } st_e;
endpackage

// File: rtl/sw_i2c_sampler.sv
module sw_i2c_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // data edge while clock held high
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/sw_ctl_reg.sv
module sw_ctl_reg
  import sw_i2c_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [BYTE_W-1:0] data_i,
  output ctl_t              ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (commit_i) ctl_q <= ctl_t'(data_i);
  end

  assign ctl_o = ctl_q;

  AST_CTL_ONLY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctl_q) |-> $past(commit_i)); // R7
endmodule

// File: rtl/sw_status_gen.sv
module sw_status_gen #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              read_start_i,
  input  logic              s1_open_i,
  input  logic              s1_gnd_i,
  input  logic              s2_open_i,
  input  logic              s2_gnd_i,
  output logic [BYTE_W-1:0] status_o
);
  logic por_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           por_q <= 1'b1;
    else if (read_start_i) por_q <= 1'b0;
  end

  always_comb begin
    status_o    = '0;
    status_o[7] = por_q;
    status_o[5] = s1_open_i;
    status_o[4] = s1_gnd_i;
    status_o[3] = s2_open_i;
    status_o[2] = s2_gnd_i;
  end

  AST_POR_STICKY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_q |=> !por_q); // R6
endmodule

// File: rtl/sw_i2c_slave.sv
module sw_i2c_slave
  import sw_i2c_pkg::*;
#(
  parameter int          BYTE_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  ADDR_BASE   = 7'b1001000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       addr_sel_i,
  input  logic       s1_open_i,
  input  logic       s1_gnd_i,
  input  logic       s2_open_i,
  input  logic       s2_gnd_i,
  output logic       gain_o,
  output logic       vmode_o,
  output logic [2:0] vsrc_o,
  output logic [2:0] asrc_o
);
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;
  logic [ADDR_W-1:0] dev_addr;
  logic [BYTE_W-1:0] sr_q, tx_q, status_w;
  logic [CNT_W-1:0]  cnt_q;
  logic              pull_q, rw_q, first_q, mack_q;
  logic              commit_w, read_start_w, byte_done;
  st_e               st_q;
  ctl_t              ctl_w;

  sw_i2c_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_w), .stop_o(stop_w)
  );

  assign dev_addr     = {ADDR_BASE[ADDR_W-1:1], addr_sel_i};
  assign byte_done    = scl_fall && (cnt_q == CNT_FULL);
  assign commit_w     = (st_q == ST_WR) && byte_done && first_q;
  assign read_start_w = (st_q == ST_AACK) && scl_fall && rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      tx_q    <= '0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      mack_q  <= 1'b0;
    end else if (stop_w) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pull_q <= 1'b0;
    end else if (start_w) begin
      st_q   <= ST_ADDR;
      cnt_q  <= '0;
      pull_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            sr_q  <= {sr_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_done) begin
            if (st_q == ST_WR) begin
              pull_q  <= 1'b1;
              first_q <= 1'b0;
              st_q    <= ST_WACK;
            end else if (sr_q[BYTE_W-1:1] == dev_addr) begin
              pull_q <= 1'b1;
              rw_q   <= sr_q[0];
              st_q   <= ST_AACK;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q   <= status_w;
              pull_q <= ~status_w[BYTE_W-1];
              st_q   <= ST_RD;
            end else begin
              pull_q  <= 1'b0;
              first_q <= 1'b1;
              st_q    <= ST_WR;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            pull_q <= 1'b0;
            cnt_q  <= '0;
            st_q   <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_done) begin
            pull_q <= 1'b0;
            st_q   <= ST_RACK;
          end else if (scl_fall) begin
            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
            pull_q <= ~tx_q[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_q   <= status_w;
              pull_q <= ~status_w[BYTE_W-1];
              cnt_q  <= '0;
              st_q   <= ST_RD;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  sw_status_gen #(.BYTE_W(BYTE_W)) u_stat (
    .clk_i, .rst_ni, .read_start_i(read_start_w),
    .s1_open_i, .s1_gnd_i, .s2_open_i, .s2_gnd_i,
    .status_o(status_w)
  );

  sw_ctl_reg #(.BYTE_W(BYTE_W)) u_ctl (
    .clk_i, .rst_ni, .commit_i(commit_w), .data_i(sr_q), .ctl_o(ctl_w)
  );

  assign sda_pull_o = pull_q;
  assign gain_o     = ctl_w.gain;
  assign vmode_o    = ctl_w.vmode;
  assign vsrc_o     = ctl_w.vsrc;
  assign asrc_o     = ctl_w.asrc;

  AST_ADDR_ACK_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pull_q) && st_q == ST_AACK) |-> (sr_q[BYTE_W-1:1] == dev_addr)); // R1
  AST_PULL_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> !scl_s); // R10
  AST_START_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (st_q == ST_ADDR && cnt_q == '0 && !pull_q)); // R7
  AST_RACK_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RACK) |-> !pull_q); // R9
endmodule

// File: tb/sw_i2c_slave_test.sv
module sw_i2c_slave_test;
  localparam int H = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
  logic s1o = 1'b0, s1g = 1'b0, s2o = 1'b0, s2g = 1'b0;
  logic pull, gain, vmode;
  logic [2:0] vsrc, asrc;
  wire  sda_bus = m_sda & ~pull;
  int checks = 0, errors = 0;
  logic [7:0] exp_ctl = 8'h00;

  always #4 clk = ~clk;

  sw_i2c_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull_o(pull), .addr_sel_i(strap),
    .s1_open_i(s1o), .s1_gnd_i(s1g), .s2_open_i(s2o), .s2_gnd_i(s2g),
    .gain_o(gain), .vmode_o(vmode), .vsrc_o(vsrc), .asrc_o(asrc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(); repeat (H) @(negedge clk); endtask

  task automatic start_c();
    if (!m_scl) begin m_sda = 1'b1; hw(); m_scl = 1'b1; hw(); end
    m_sda = 1'b0; hw(); m_scl = 1'b0; hw();
  endtask

  task automatic stop_c();
    m_sda = 1'b0; hw(); m_scl = 1'b1; hw(); m_sda = 1'b1; hw();
  endtask

  task automatic put_bit(input bit b);
    m_sda = b; hw(); m_scl = 1'b1; hw(); m_scl = 1'b0;
  endtask

  // ack bit: sample twice during SCL high, check stability (R10)
  task automatic get_bit(output bit b);
    bit a0, a1;
    hw(); m_scl = 1'b1;
    repeat (H/2) @(negedge clk); a0 = sda_bus;
    repeat (H/2) @(negedge clk); a1 = sda_bus;
    m_scl = 1'b0;
    chk(a0 == a1, "R10 sda stable while scl high", a1, a0);
    b = a1;
  endtask

  task automatic put_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    m_sda = 1'b1; get_bit(b); ack = ~b;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] d);
    bit b;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~give_ack);
  endtask

  task automatic chk_ctl(input string tag);
    chk({gain, vmode, vsrc, asrc} == exp_ctl, tag, {gain, vmode, vsrc, asrc}, exp_ctl);
  endtask

  // {strap, address byte, data byte, expect ack}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 8'h90, 8'hA5, 1'b1},
    {1'b0, 8'h92, 8'h3C, 1'b0},
    {1'b1, 8'h92, 8'h3C, 1'b1},
    {1'b1, 8'h90, 8'hFF, 1'b0},
    {1'b1, 8'h92, 8'h80, 1'b1},
    {1'b0, 8'h90, 8'h47, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk(pull == 1'b0, "R4 sda released in reset", pull, 0);
    chk({gain, vmode, vsrc, asrc} == 8'h00, "R4 ctl zero in reset", {gain, vmode, vsrc, asrc}, 0);
    rst_n = 1'b1;
    hw();
    chk_ctl("R4 ctl zero after reset");

    // R1 R2 table
    for (int k = 0; k < 6; k++) begin
      strap = VEC[k][17];
      hw();
      start_c();
      put_byte(VEC[k][16:9], ack);
      chk(ack == VEC[k][0], "R1 address ack", ack, VEC[k][0]);
      if (ack) begin
        put_byte(VEC[k][8:1], ack);
        chk(ack, "R2 data ack", ack, 1);
        exp_ctl = VEC[k][8:1];
      end
      stop_c();
      chk_ctl("R2 ctl fields");
    end

    // R5 R6 R9: first read, two bytes
    strap = 1'b0; s1o = 1'b1; s1g = 1'b0; s2o = 1'b0; s2g = 1'b1;
    start_c();
    put_byte(8'h91, ack);
    chk(ack, "R1 read address ack", ack, 1);
    get_byte(1'b1, d);
    chk(d == 8'hA4, "R5 R6 first status", d, 8'hA4);
    get_byte(1'b0, d);
    chk(d == 8'h24, "R9 R6 second status after master ack", d, 8'h24);
    hw();
    chk(pull == 1'b0, "R9 released after master nak", pull, 0);
    stop_c();

    // R5 R6 second read, other pattern, strap 1
    strap = 1'b1; s1o = 1'b0; s1g = 1'b1; s2o = 1'b1; s2g = 1'b0;
    start_c();
    put_byte(8'h93, ack);
    get_byte(1'b0, d);
    chk(d == 8'h18, "R5 R6 later status", d, 8'h18);
    stop_c();

    // R3 extra bytes dropped
    strap = 1'b0;
    start_c();
    put_byte(8'h90, ack);
    put_byte(8'h11, ack);
    put_byte(8'h22, ack);
    chk(ack, "R3 extra byte acked", ack, 1);
    put_byte(8'h33, ack);
    stop_c();
    exp_ctl = 8'h11;
    chk_ctl("R3 extra bytes ignored");

    // R7 truncated write via stop
    start_c();
    put_byte(8'h90, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    stop_c();
    chk_ctl("R7 truncated write leaves ctl");

    // R7 R8 abort mid-byte by repeated start
    start_c();
    put_byte(8'h90, ack);
    for (int i = 0; i < 5; i++) put_bit(i[0]);
    start_c();
    put_byte(8'h90, ack);
    chk(ack, "R8 address after repeated start", ack, 1);
    put_byte(8'h5A, ack);
    stop_c();
    exp_ctl = 8'h5A;
    chk_ctl("R7 R8 write after abort");

    // R8 write then repeated start into read
    start_c();
    put_byte(8'h90, ack);
    put_byte(8'h66, ack);
    start_c();
    put_byte(8'h91, ack);
    chk(ack, "R8 read after repeated start", ack, 1);
    get_byte(1'b0, d);
    chk(d == 8'h18, "R8 status after repeated start", d, 8'h18);
    stop_c();
    exp_ctl = 8'h66;
    chk_ctl("R8 ctl from combined transfer");

    // R1 mismatch then data ignored
    start_c();
    put_byte(8'h94, ack);
    chk(!ack, "R1 mismatch no ack", ack, 0);
    put_byte(8'h00, ack);
    chk(!ack, "R1 data after mismatch no ack", ack, 0);
    stop_c();
    chk_ctl("R1 ctl unchanged after mismatch");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule